// File: doc/BRIEF.md
# Grouped GPIO Controller with Edge Interrupts

This block runs a bank of general-purpose pins through a register port. An ownership mask decides which pins it controls. Pins that are not owned belong to some other function. The block never drives them and ignores every write aimed at them. Each owned pin has three settings: a direction, a drive style (push-pull or open-drain) and a high-impedance override. Output levels are held in a level register. Software can raise or lower single pins with set and clear strobes. It can also write a whole group of pins with one access. The group is chosen by a mask.

A group write does not reach the pins all at once. The bank is cut into 4-pin slices. The sequencer applies one slice per clock, from the lowest slice upward. A group write that arrives while a sequence is still running waits in a one-deep holding slot. A group read returns the synchronized input levels, masked by the group.

Each input passes through a two-flop synchronizer. A rising or falling transition on an owned input pin can then set a sticky status bit, if that edge type is enabled for the pin. Software clears a status bit by writing 1 to it. The interrupt output is high whenever any status bit is set.

Top module: `gpio_grp_ctrl`

## Requirements
- R1: After reset every register reads 0, `pin_oe` and `pin_out` are all 0 and `irq` is 0 (with `pin_in` held low).
- R2: A 1 in the ownership register (address 0) gives the pin to this block. A pin that is not owned has `pin_oe` and `pin_out` at 0. Set, clear and group writes leave its stored level (read at address 8) unchanged, and its input never sets a status bit.
- R3: On the clock edge that captures it, a write to address 4 sets the stored level of every owned pin with a 1 in the data. A write to address 5 clears those levels in the same way.
- R4: A write to address 7 loads the written data into the owned pins selected by the group mask (address 6). Slice k covers pins 4k to 4k+3. It is applied on the (k+1)-th clock edge after the edge that captures the write. Pins outside the mask keep their level.
- R5: A group write captured while a sequence is running is held. Its slice 0 is applied on the edge right after the last slice of the running sequence. A further group write captured while one is held replaces the held one.
- R6: A read of address 7 returns the synchronized input levels ANDed with the group mask, bit for bit.
- R7: A 1 in the direction register (address 1) makes a pin an output. An owned push-pull output that is not in high impedance has `pin_oe`=1 and `pin_out` equal to its stored level. An owned input has `pin_oe`=0 and `pin_out`=0.
- R8: A 1 in the drive-style register (address 2) makes an owned output open-drain. Level 1 gives `pin_oe`=0. Level 0 gives `pin_oe`=1 and `pin_out`=0. `pin_out` is never 1 on such a pin.
- R9: A 1 in the high-impedance register (address 3) forces `pin_oe` and `pin_out` to 0 for that pin, whatever its other settings.
- R10: Address 9 reads the input levels. A change on `pin_in` shows there after the second clock edge, and not after the first.
- R11: The rising-edge enable (address 10) and falling-edge enable (address 11) act on owned pins whose direction is input. An enabled transition sets that pin's status bit (address 12) on the third clock edge after the input changes. Disabled edges and output pins leave the status unchanged.
- R12: A status bit stays set until a write to address 12 with a 1 in that bit. A 0 in the written data leaves the bit as it is. `irq` is 1 exactly when some status bit is set.
- R13: The registers at addresses 0, 1, 2, 3, 6, 10 and 11 read back the last value written. Address 8 reads the stored levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register address for writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 32 | Pin input levels, asynchronous |
| pin_out | output | 32 | Pin output levels |
| pin_oe | output | 32 | Pin output enables |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
The assertions assume that `pin_in` stays low through reset, so the synchronizer never sees a false edge when reset is released. They also assume that each register write lasts exactly one cycle. The slice-containment property is only claimed in cycles with no set or clear write, because those strobes may touch any owned pin while a group sequence is running. The stimulus follows all of this: inputs are low during reset, every write is a single-cycle strobe driven on the falling clock edge, and set and clear writes are issued only while no group sequence is running.

// File: rtl/gpio_grp_pkg.sv
`timescale 1ns/1ps
package gpio_grp_pkg;
  localparam int unsigned DEF_PINS    = 32;
  localparam int unsigned DEF_SLICE_W = 4;
  localparam int unsigned ADDR_W      = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_OWN   = 4'd0,
    RA_DIR   = 4'd1,
    RA_ODRN  = 4'd2,
    RA_HIZ   = 4'd3,
    RA_SET   = 4'd4,
    RA_CLR   = 4'd5,
    RA_GMASK = 4'd6,
    RA_GDATA = 4'd7,
    RA_LEVEL = 4'd8,
    RA_IN    = 4'd9,
    RA_RISE  = 4'd10,
    RA_FALL  = 4'd11,
    RA_STAT  = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/gpio_pad_drv.sv
`timescale 1ns/1ps
module gpio_pad_drv (
  input  logic owned,
  input  logic is_out,
  input  logic odrn,
  input  logic hiz,
  input  logic level,
  output logic pad_out,
  output logic pad_oe
);
  logic active;
  assign active = owned && is_out && !hiz;

  always_comb begin
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    if (active) begin
      if (odrn) begin
        pad_oe = !level;
      end else begin
        pad_oe  = 1'b1;
        pad_out = level;
      end
    end
  end
endmodule

// File: rtl/gpio_slice_seq.sv
`timescale 1ns/1ps
module gpio_slice_seq #(
  parameter int unsigned PINS    = 32,
  parameter int unsigned SLICE_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [PINS-1:0]            go_data,
  input  logic [PINS-1:0]            go_mask,
  output logic                       busy,
  output logic                       pend_valid,
  output logic [PINS-1:0]            apply_mask,
  output logic [PINS-1:0]            apply_data,
  output logic [PINS/SLICE_W-1:0]    strobe
);
  localparam int unsigned NSL   = PINS / SLICE_W;
  localparam int unsigned IDX_W = (NSL > 1) ? $clog2(NSL) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSL - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic [PINS-1:0]  stage_data_q, stage_mask_q;
  logic [PINS-1:0]  pend_data_q, pend_mask_q;
  logic             pend_q;

  function automatic logic [PINS-1:0] slice_bits(input logic [IDX_W-1:0] k);
    logic [PINS-1:0] bits;
    for (int i = 0; i < PINS; i++) begin
      bits[i] = ((i / SLICE_W) == int'(k));
    end
    return bits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      idx_q        <= '0;
      stage_data_q <= '0;
      stage_mask_q <= '0;
      pend_data_q  <= '0;
      pend_mask_q  <= '0;
      pend_q       <= 1'b0;
    end else if (busy_q) begin
      if (idx_q == LAST_IDX) begin
        idx_q <= '0;
        if (pend_q) begin
          stage_data_q <= pend_data_q;
          stage_mask_q <= pend_mask_q;
          if (go) begin
            pend_data_q <= go_data;
            pend_mask_q <= go_mask;
          end else begin
            pend_q <= 1'b0;
          end
        end else if (go) begin
          stage_data_q <= go_data;
          stage_mask_q <= go_mask;
        end else begin
          busy_q <= 1'b0;
        end
      end else begin
        idx_q <= idx_q + 1'b1;
        if (go) begin
          pend_data_q <= go_data;
          pend_mask_q <= go_mask;
          pend_q      <= 1'b1;
        end
      end
    end else if (go) begin
      stage_data_q <= go_data;
      stage_mask_q <= go_mask;
      busy_q       <= 1'b1;
      idx_q        <= '0;
    end
  end

  assign busy       = busy_q;
  assign pend_valid = pend_q;
  assign apply_data = stage_data_q;
  assign apply_mask = busy_q ? (stage_mask_q & slice_bits(idx_q)) : '0;

  for (genvar k = 0; k < NSL; k++) begin : g_strobe
    assign strobe[k] = busy_q && (idx_q == IDX_W'(k));
  end
endmodule

// File: rtl/gpio_edge_irq.sv
`timescale 1ns/1ps
module gpio_edge_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] arm,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] sync_lvl,
  output logic [W-1:0] rise_evt,
  output logic [W-1:0] fall_evt,
  output logic [W-1:0] stat
);
  logic [W-1:0] meta_q, sync_q, prev_q, stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
      stat_q <= (stat_q & ~clr_mask) | rise_evt | fall_evt;
    end
  end

  assign rise_evt = sync_q & ~prev_q & arm & rise_en;
  assign fall_evt = ~sync_q & prev_q & arm & fall_en;
  assign sync_lvl = sync_q;
  assign stat     = stat_q;
endmodule

// File: rtl/gpio_grp_ctrl.sv
`timescale 1ns/1ps
module gpio_grp_ctrl
  import gpio_grp_pkg::*;
#(
  parameter int unsigned PINS    = DEF_PINS,
  parameter int unsigned SLICE_W = DEF_SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [PINS-1:0]   reg_wdata,
  output logic [PINS-1:0]   reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  localparam int unsigned NSL = PINS / SLICE_W;

  logic [PINS-1:0] own_q, dir_q, odrn_q, hiz_q, gmask_q, level_q, rise_q, fall_q;
  logic [PINS-1:0] level_nxt, stat_q, stat_clr, sync_lvl, rise_evt, fall_evt;
  logic [PINS-1:0] seq_apply_mask, seq_data;
  logic [NSL-1:0]  slice_strobe;
  logic            seq_busy, pend_valid, lv_touch;
  logic            we_own, we_dir, we_odrn, we_hiz, we_set, we_clr;
  logic            we_gmask, we_gdata, we_rise, we_fall, we_stat;
  reg_addr_e       addr_e;

  function automatic logic [PINS-1:0] merge_bits(input logic [PINS-1:0] old_v,
                                                 input logic [PINS-1:0] new_v,
                                                 input logic [PINS-1:0] sel);
    return (old_v & ~sel) | (new_v & sel);
  endfunction

  assign addr_e   = reg_addr_e'(reg_addr);
  assign we_own   = reg_we && (addr_e == RA_OWN);
  assign we_dir   = reg_we && (addr_e == RA_DIR);
  assign we_odrn  = reg_we && (addr_e == RA_ODRN);
  assign we_hiz   = reg_we && (addr_e == RA_HIZ);
  assign we_set   = reg_we && (addr_e == RA_SET);
  assign we_clr   = reg_we && (addr_e == RA_CLR);
  assign we_gmask = reg_we && (addr_e == RA_GMASK);
  assign we_gdata = reg_we && (addr_e == RA_GDATA);
  assign we_rise  = reg_we && (addr_e == RA_RISE);
  assign we_fall  = reg_we && (addr_e == RA_FALL);
  assign we_stat  = reg_we && (addr_e == RA_STAT);
  assign lv_touch = we_set || we_clr;
  assign stat_clr = we_stat ? reg_wdata : '0;

  gpio_slice_seq #(.PINS(PINS), .SLICE_W(SLICE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (we_gdata),
    .go_data    (reg_wdata),
    .go_mask    (gmask_q & own_q),
    .busy       (seq_busy),
    .pend_valid (pend_valid),
    .apply_mask (seq_apply_mask),
    .apply_data (seq_data),
    .strobe     (slice_strobe)
  );

  gpio_edge_irq #(.W(PINS)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .arm      (own_q & ~dir_q),
    .rise_en  (rise_q),
    .fall_en  (fall_q),
    .clr_mask (stat_clr),
    .sync_lvl (sync_lvl),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt),
    .stat     (stat_q)
  );

  always_comb begin
    level_nxt = merge_bits(level_q, seq_data, seq_apply_mask & own_q);
    if (we_set) level_nxt = level_nxt | (reg_wdata & own_q);
    if (we_clr) level_nxt = level_nxt & ~(reg_wdata & own_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q   <= '0;
      dir_q   <= '0;
      odrn_q  <= '0;
      hiz_q   <= '0;
      gmask_q <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      level_q <= '0;
    end else begin
      if (we_own)   own_q   <= reg_wdata;
      if (we_dir)   dir_q   <= reg_wdata;
      if (we_odrn)  odrn_q  <= reg_wdata;
      if (we_hiz)   hiz_q   <= reg_wdata;
      if (we_gmask) gmask_q <= reg_wdata;
      if (we_rise)  rise_q  <= reg_wdata;
      if (we_fall)  fall_q  <= reg_wdata;
      level_q <= level_nxt;
    end
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pad
    gpio_pad_drv u_pad (
      .owned   (own_q[p]),
      .is_out  (dir_q[p]),
      .odrn    (odrn_q[p]),
      .hiz     (hiz_q[p]),
      .level   (level_q[p]),
      .pad_out (pin_out[p]),
      .pad_oe  (pin_oe[p])
    );
  end

  always_comb begin
    case (addr_e)
      RA_OWN:   reg_rdata = own_q;
      RA_DIR:   reg_rdata = dir_q;
      RA_ODRN:  reg_rdata = odrn_q;
      RA_HIZ:   reg_rdata = hiz_q;
      RA_GMASK: reg_rdata = gmask_q;
      RA_GDATA: reg_rdata = sync_lvl & gmask_q;
      RA_LEVEL: reg_rdata = level_q;
      RA_IN:    reg_rdata = sync_lvl;
      RA_RISE:  reg_rdata = rise_q;
      RA_FALL:  reg_rdata = fall_q;
      RA_STAT:  reg_rdata = stat_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |stat_q;
endmodule

// File: rtl/gpio_grp_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_grp_ctrl_chk #(
  parameter int unsigned PINS    = 32,
  parameter int unsigned SLICE_W = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [PINS-1:0]         own_q,
  input logic [PINS-1:0]         odrn_q,
  input logic [PINS-1:0]         level_q,
  input logic [PINS-1:0]         pin_out,
  input logic [PINS-1:0]         pin_oe,
  input logic [PINS-1:0]         seq_apply_mask,
  input logic                    seq_busy,
  input logic                    pend_valid,
  input logic                    lv_touch,
  input logic [PINS/SLICE_W-1:0] slice_strobe,
  input logic [PINS-1:0]         stat_q,
  input logic [PINS-1:0]         stat_clr,
  input logic [PINS-1:0]         rise_q,
  input logic [PINS-1:0]         fall_q
);
  // R2: pins owned elsewhere stay undriven
  p_foreign_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_oe | pin_out) & ~own_q) == '0);

  // R2: stored level of a foreign pin never moves
  p_foreign_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy || lv_touch) |=> ((level_q ^ $past(level_q)) & ~$past(own_q)) == '0);

  // R4: a sequence step only changes pins of the current slice
  p_slice_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && !lv_touch) |=> ((level_q ^ $past(level_q)) & ~$past(seq_apply_mask)) == '0);

  // R4: at most one slice is applied per clock
  p_one_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slice_strobe));

  // R5: a held write only exists while a sequence runs
  p_pend_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid |-> seq_busy);

  // R8: open-drain pins never drive high
  p_od_no_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & odrn_q & own_q) == '0);

  // R11: newly set status bits must have an enabled edge
  p_stat_enabled_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy || !seq_busy |=> ((stat_q & ~$past(stat_q)) & ~($past(rise_q) | $past(fall_q))) == '0);

  // R12: status bits are sticky without a clear write
  p_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr == '0) |=> ($past(stat_q) & ~stat_q) == '0);
endmodule

bind gpio_grp_ctrl gpio_grp_ctrl_chk #(.PINS(PINS), .SLICE_W(SLICE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .own_q          (own_q),
  .odrn_q         (odrn_q),
  .level_q        (level_q),
  .pin_out        (pin_out),
  .pin_oe         (pin_oe),
  .seq_apply_mask (seq_apply_mask),
  .seq_busy       (seq_busy),
  .pend_valid     (pend_valid),
  .lv_touch       (lv_touch),
  .slice_strobe   (slice_strobe),
  .stat_q         (stat_q),
  .stat_clr       (stat_clr),
  .rise_q         (rise_q),
  .fall_q         (fall_q)
);

// File: tb/gpio_grp_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_grp_ctrl_tb_top;
  import gpio_grp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  gpio_grp_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_total++; n_fail++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    for (int a = 0; a < 13; a++) rd_check("R1 register", 4'(a), 32'h0);

    // R13 read-back
    wr(RA_OWN, 32'hFFFF_FFFF);   wr(RA_DIR, 32'hA5A5_0F0F);
    wr(RA_ODRN, 32'h1234_5678);  wr(RA_HIZ, 32'h0F00_00F0);
    wr(RA_GMASK, 32'h00FF_00FF); wr(RA_RISE, 32'hDEAD_BEEF);
    wr(RA_FALL, 32'h0F0F_F0F0);
    rd_check("R13 own", RA_OWN, 32'hFFFF_FFFF);
    rd_check("R13 dir", RA_DIR, 32'hA5A5_0F0F);
    rd_check("R13 odrn", RA_ODRN, 32'h1234_5678);
    rd_check("R13 hiz", RA_HIZ, 32'h0F00_00F0);
    rd_check("R13 gmask", RA_GMASK, 32'h00FF_00FF);
    rd_check("R13 rise", RA_RISE, 32'hDEAD_BEEF);
    rd_check("R13 fall", RA_FALL, 32'h0F0F_F0F0);
    wr(RA_RISE, 32'h0); wr(RA_FALL, 32'h0);

    // R2 R7 R8 R9 pad sweep on pin 5, every configuration and level
    for (int c = 0; c < 16; c++) begin
      for (int lv = 0; lv < 2; lv++) begin
        logic own_b, dir_b, od_b, hz_b, e_oe, e_out;
        string tag;
        own_b = c[0]; dir_b = c[1]; od_b = c[2]; hz_b = c[3];
        wr(RA_OWN, 32'h20);
        wr(lv != 0 ? RA_SET : RA_CLR, 32'h20);
        wr(RA_DIR, dir_b ? 32'h20 : 32'h0);
        wr(RA_ODRN, od_b ? 32'h20 : 32'h0);
        wr(RA_HIZ, hz_b ? 32'h20 : 32'h0);
        wr(RA_OWN, own_b ? 32'h20 : 32'h0);
        e_oe = 1'b0; e_out = 1'b0;
        if (!own_b)      tag = "R2 pad foreign";
        else if (!dir_b) tag = "R7 pad input";
        else if (hz_b)   tag = "R9 pad hiz";
        else if (od_b) begin tag = "R8 pad open-drain"; e_oe = (lv == 0); end
        else begin tag = "R7 pad push-pull"; e_oe = 1'b1; e_out = (lv != 0); end
        check(tag, {30'h0, pin_oe[5], pin_out[5]}, {30'h0, e_oe, e_out});
      end
    end

    // R3 set and clear
    wr(RA_OWN, 32'hFFFF_FFFF); wr(RA_DIR, 32'hFFFF_FFFF);
    wr(RA_ODRN, 32'h0); wr(RA_HIZ, 32'h0); wr(RA_CLR, 32'hFFFF_FFFF);
    wr(RA_SET, 32'h8000_0001);
    rd_check("R3 set level", RA_LEVEL, 32'h8000_0001);
    check("R3 set pins", pin_out, 32'h8000_0001);
    wr(RA_CLR, 32'h0000_0001);
    rd_check("R3 clear level", RA_LEVEL, 32'h8000_0000);
    wr(RA_CLR, 32'hFFFF_FFFF);

    // R2 ownership blocks writes
    wr(RA_OWN, 32'h0000_FFFF);
    wr(RA_SET, 32'hFFFF_FFFF);
    rd_check("R2 set only owned", RA_LEVEL, 32'h0000_FFFF);
    check("R2 oe only owned", pin_oe, 32'h0000_FFFF);
    wr(RA_GMASK, 32'hFFFF_FFFF);
    wr(RA_GDATA, 32'hFFFF_0000);
    idle(10);
    rd_check("R2 group only owned", RA_LEVEL, 32'h0000_0000);
    wr(RA_OWN, 32'hFFFF_FFFF);
    rd_check("R2 foreign level kept", RA_LEVEL, 32'h0000_0000);

    // R4 slice timing on an 8-pin group
    wr(RA_GMASK, 32'h0000_00FF);
    wr(RA_GDATA, 32'h0000_00FF);
    check("R4 no change at capture", pin_out, 32'h0);
    idle(1);
    check("R4 low slice first", pin_out, 32'h0000_000F);
    idle(1);
    check("R4 high slice next", pin_out, 32'h0000_00FF);
    idle(8);
    wr(RA_CLR, 32'hFFFF_FFFF);

    // R4 mask keeps outside pins
    wr(RA_GMASK, 32'h0F0F_0F0F);
    wr(RA_GDATA, 32'hFFFF_FFFF);
    idle(10);
    rd_check("R4 masked group", RA_LEVEL, 32'h0F0F_0F0F);
    wr(RA_CLR, 32'hFFFF_FFFF);

    // R4 full-bank slice sweep
    wr(RA_GMASK, 32'hFFFF_FFFF);
    wr(RA_GDATA, 32'hFFFF_FFFF);
    for (int k = 0; k < 8; k++) begin
      logic [63:0] e64;
      idle(1);
      e64 = (64'd1 << (4 * (k + 1))) - 64'd1;
      check("R4 slice sweep", pin_out, e64[31:0]);
    end
    idle(2);

    // R5 held writes, the last one replaces the held one
    wr(RA_GDATA, 32'h0000_0000);
    wr(RA_GDATA, 32'h1234_5678);
    wr(RA_GDATA, 32'h0000_AAAA);
    idle(4);
    check("R5 first sequence done", pin_out, 32'h0000_0000);
    idle(1);
    check("R5 next starts at once", pin_out, 32'h0000_000A);
    idle(9);
    rd_check("R5 held write replaced", RA_LEVEL, 32'h0000_AAAA);

    // R10 and R6 input path
    wr(RA_DIR, 32'h0);
    @(negedge clk); pin_in = 32'h0000_0005;
    idle(1);
    rd_check("R10 not after one edge", RA_IN, 32'h0);
    idle(1);
    rd_check("R10 after two edges", RA_IN, 32'h0000_0005);
    pin_in = 32'hF0F0_1234;
    idle(3);
    wr(RA_GMASK, 32'hFFFF_00FF);
    rd_check("R6 group read", RA_GDATA, 32'hF0F0_0034);
    rd_check("R10 input read", RA_IN, 32'hF0F0_1234);
    rd_check("R11 no enabled edges", RA_STAT, 32'h0);
    pin_in = 32'h0;
    idle(4);

    // R11 and R12 edges and sticky status
    wr(RA_RISE, 32'h1); wr(RA_FALL, 32'h2);
    @(negedge clk); pin_in = 32'h7;
    idle(2);
    rd_check("R11 not before third edge", RA_STAT, 32'h0);
    idle(1);
    rd_check("R11 rise sets status", RA_STAT, 32'h1);
    check("R12 irq high", {31'h0, irq}, 32'h1);
    pin_in = 32'h0;
    idle(3);
    rd_check("R11 fall sets status", RA_STAT, 32'h3);
    wr(RA_STAT, 32'h0);
    rd_check("R12 zero write keeps", RA_STAT, 32'h3);
    wr(RA_STAT, 32'h1);
    rd_check("R12 clear one bit", RA_STAT, 32'h2);
    check("R12 irq still high", {31'h0, irq}, 32'h1);
    wr(RA_STAT, 32'h2);
    rd_check("R12 all clear", RA_STAT, 32'h0);
    check("R12 irq low", {31'h0, irq}, 32'h0);

    // R11 output pin ignored, R2 foreign pin ignored
    wr(RA_DIR, 32'h8); wr(RA_RISE, 32'hFFFF_FFFF); wr(RA_FALL, 32'h0);
    pin_in = 32'h8; idle(4);
    rd_check("R11 output pin no status", RA_STAT, 32'h0);
    pin_in = 32'h0; idle(4);
    wr(RA_DIR, 32'h0); wr(RA_OWN, 32'hFFFF_FFFE);
    pin_in = 32'h1; idle(4);
    rd_check("R2 foreign pin no status", RA_STAT, 32'h0);
    pin_in = 32'h0; idle(4);
    wr(RA_OWN, 32'hFFFF_FFFF);

    // R11 sweep: each pin's rise sets its own bit
    for (int p = 0; p < 32; p++) begin
      pin_in = 32'h1 << p;
      idle(4);
      rd_check("R11 per-pin rise", RA_STAT, 32'h1 << p);
      wr(RA_STAT, 32'hFFFF_FFFF);
      pin_in = 32'h0;
      idle(4);
    end
    rd_check("R11 falls disabled", RA_STAT, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule